// File: doc/BRIEF.md
# Fractional-Divisor Baud Tick Generator

This block takes one source clock and produces two periodic enable pulses. The first is a sub-clock tick for an infrared pulse shaper, intended to run near 1.8432 MHz. The second is a 16x oversampling tick for a UART bit clock. Each channel has an integer divisor and a 4-bit fractional correction in sixteenths of a source clock period. A small phase accumulator lengthens selected periods by one clock, so that the long-run average period is the integer divisor plus the fraction.

Software loads four byte-wide settings through a one-cycle write strobe. Working out the divisor values, choosing the clock source and the UART datapath all sit outside this block. Both outputs are single-cycle enables in the source clock domain. Neither is a derived clock.

Top module: `baud_tick_gen`

## Requirements
- R1: In reset `ir_tick`, `uart_tick` and `cfg_err` are 0. The infrared setting resets to raw 1 (period 2) and the UART count resets to 0 (period 16), with both fractions at 0. After release, `ir_tick` is first high in the 1st cycle and `uart_tick` in the 15th cycle.
- R2: Address 0 holds the infrared integer setting in bits [3:0]; bits [7:4] of the write are ignored. The infrared base period P is this setting plus one, in source clocks.
- R3: Address 2 holds the 8-bit UART count C. The UART base period P is (C+1)*16 source clocks.
- R4: The fraction F (0..15) is taken from bits [7:4] of a write to address 1 (infrared) or address 3 (UART). Bits [3:0] of those writes have no effect.
- R5: Every tick period is P or P+1. A 4-bit accumulator adds F at each tick. A carry lengthens the next period by one clock, so the k-th period after a restart (k ≥ 1) lasts P + floor(kF/16) − floor((k−1)F/16). Any 16 such consecutive periods starting at k=1 sum to 16P+F.
- R6: A write to either register of a channel takes effect at once and marks that channel for restart. At the first tick after the write the accumulator is cleared, and the period that follows lasts exactly P.
- R7: Writing a value whose bits [3:0] are zero to address 0 leaves the infrared setting unchanged and does not restart that channel. It sets `cfg_err`, which stays set until reset.
- R8: Each tick is high for one cycle only. The infrared tick never stays low for more than 16 consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 2 | Register select: 0 IR integer, 1 IR fraction, 2 UART count, 3 UART fraction |
| wr_data | input | 8 | Write data |
| ir_tick | output | 1 | Infrared sub-clock enable pulse |
| uart_tick | output | 1 | UART 16x oversampling enable pulse |
| cfg_err | output | 1 | Sticky flag: illegal zero infrared setting was written |

## Verification
A tick is decoded from the counter registers. It is therefore visible in the same cycle in which the counter reaches its last count, and a register write changes state at the edge that samples the strobe. The bench drives and samples on falling edges. After a write's strobe is removed, the next sampled tick is the restart boundary, and every period is counted as the number of falling edges between successive ticks. `cfg_err` is due at the first falling edge after the illegal write. The reset timing is checked by counting falling edges from release: 1 for the infrared tick and 15 for the UART tick.

// File: rtl/baud_pkg.sv
// Shared widths and register addresses for the baud tick generator.
// Assumes byte-wide writes; fraction fields sit in the upper nibble.
package baud_pkg;
    localparam int ADDR_W   = 2;
    localparam int DATA_W   = 8;
    localparam int IR_W     = 4;
    localparam int UA_W     = 8;
    localparam int FRAC_W   = 4;
    localparam int FRAC_LSB = 4;
    localparam int OVS_LOG2 = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_IR_INT  = 2'd0,
        A_IR_FRAC = 2'd1,
        A_UA_CNT  = 2'd2,
        A_UA_FRAC = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/baud_cfg_regs.sv
// Configuration registers for both tick channels.
// Rejects a zero infrared setting and flags it; pulses a restart
// request toward the channel whose settings were written.
module baud_cfg_regs
    import baud_pkg::*;
#(
    parameter int IR_BITS   = IR_W,
    parameter int UA_BITS   = UA_W,
    parameter int FRAC_BITS = FRAC_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [IR_BITS-1:0]   ir_int_o,
    output logic [FRAC_BITS-1:0] ir_frac_o,
    output logic [UA_BITS-1:0]   ua_cnt_o,
    output logic [FRAC_BITS-1:0] ua_frac_o,
    output logic                 ir_restart_o,
    output logic                 ua_restart_o,
    output logic                 cfg_err_o
);
    logic ir_zero;
    logic hit_ir_int, hit_ir_frac, hit_ua_cnt, hit_ua_frac;

    // Decode which register a write targets and whether it is legal.
    always_comb begin
        ir_zero     = (wr_data[IR_BITS-1:0] == '0);
        hit_ir_int  = wr_en && (wr_addr == A_IR_INT);
        hit_ir_frac = wr_en && (wr_addr == A_IR_FRAC);
        hit_ua_cnt  = wr_en && (wr_addr == A_UA_CNT);
        hit_ua_frac = wr_en && (wr_addr == A_UA_FRAC);
    end

    // Hold the four settings; an illegal zero leaves the old value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_int_o  <= IR_BITS'(1);
            ir_frac_o <= '0;
            ua_cnt_o  <= '0;
            ua_frac_o <= '0;
        end else begin
            if (hit_ir_int && !ir_zero) ir_int_o  <= wr_data[IR_BITS-1:0];
            if (hit_ir_frac)            ir_frac_o <= wr_data[FRAC_LSB +: FRAC_BITS];
            if (hit_ua_cnt)             ua_cnt_o  <= wr_data[UA_BITS-1:0];
            if (hit_ua_frac)            ua_frac_o <= wr_data[FRAC_LSB +: FRAC_BITS];
        end
    end

    // Sticky record of a rejected infrared setting.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cfg_err_o <= 1'b0;
        else if (hit_ir_int && ir_zero) cfg_err_o <= 1'b1;
    end

    // Restart requests go to the channel that accepted a write.
    assign ir_restart_o = (hit_ir_int && !ir_zero) || hit_ir_frac;
    assign ua_restart_o = hit_ua_cnt || hit_ua_frac;
endmodule

// File: rtl/frac_tick_div.sv
// Fractional tick divider: pulses tick_o once per period of
// period_i or period_i+1 clocks; the accumulator carry picks the long
// periods. A restart request clears the accumulator at the next tick.
// Assumes period_i >= 2 so each tick lasts one cycle.
module frac_tick_div #(
    parameter int PW        = 5,
    parameter int FRAC_BITS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PW-1:0]        period_i,
    input  logic [FRAC_BITS-1:0] frac_i,
    input  logic                 restart_i,
    output logic                 tick_o
);
    logic [PW-1:0]        cnt_q;
    logic [FRAC_BITS-1:0] acc_q;
    logic                 stretch_q;
    logic                 pend_q;
    logic [PW:0]          len;
    logic [PW:0]          pos;
    logic [FRAC_BITS:0]   sum;
    logic                 bound;

    // Current period length and end-of-period decode.
    always_comb begin
        len   = {1'b0, period_i} + {{PW{1'b0}}, stretch_q};
        pos   = {1'b0, cnt_q} + {{PW{1'b0}}, 1'b1};
        bound = (pos >= len);
        sum   = {1'b0, acc_q} + {1'b0, frac_i};
    end

    // Cycle counter within the current period.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (bound) cnt_q <= '0;
        else            cnt_q <= cnt_q + PW'(1);
    end

    // Phase accumulator and stretch of the next period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= '0;
            stretch_q <= 1'b0;
        end else if (bound) begin
            if (pend_q) begin
                acc_q     <= '0;
                stretch_q <= 1'b0;
            end else begin
                acc_q     <= sum[FRAC_BITS-1:0];
                stretch_q <= sum[FRAC_BITS];
            end
        end
    end

    // Pending restart, consumed at the next period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)         pend_q <= 1'b0;
        else if (restart_i) pend_q <= 1'b1;
        else if (bound)     pend_q <= 1'b0;
    end

    assign tick_o = bound;
endmodule

// File: rtl/baud_tick_gen.sv
// Two-channel baud tick generator: an infrared sub-clock tick and a
// UART 16x oversampling tick, each with a sixteenth-step fraction.
// Assumes a single clock domain and one-cycle write strobes.
module baud_tick_gen
    import baud_pkg::*;
#(
    parameter int IR_BITS   = IR_W,
    parameter int UA_BITS   = UA_W,
    parameter int FRAC_BITS = FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ir_tick,
    output logic              uart_tick,
    output logic              cfg_err
);
    localparam int IR_PW = IR_BITS + 1;
    localparam int UA_PW = UA_BITS + 1 + OVS_LOG2;

    logic [IR_BITS-1:0]   ir_int;
    logic [FRAC_BITS-1:0] ir_frac;
    logic [UA_BITS-1:0]   ua_cnt;
    logic [FRAC_BITS-1:0] ua_frac;
    logic                 ir_restart, ua_restart;
    logic [IR_PW-1:0]     ir_period;
    logic [UA_PW-1:0]     ua_period;

    baud_cfg_regs #(
        .IR_BITS(IR_BITS), .UA_BITS(UA_BITS), .FRAC_BITS(FRAC_BITS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ir_int_o(ir_int), .ir_frac_o(ir_frac),
        .ua_cnt_o(ua_cnt), .ua_frac_o(ua_frac),
        .ir_restart_o(ir_restart), .ua_restart_o(ua_restart),
        .cfg_err_o(cfg_err)
    );

    // Base periods: stored value plus one, UART scaled by 16.
    always_comb begin
        ir_period = {1'b0, ir_int} + IR_PW'(1);
        ua_period = {({1'b0, ua_cnt} + (UA_BITS+1)'(1)), {OVS_LOG2{1'b0}}};
    end

    frac_tick_div #(.PW(IR_PW), .FRAC_BITS(FRAC_BITS)) u_ir_div (
        .clk(clk), .rst_n(rst_n),
        .period_i(ir_period), .frac_i(ir_frac),
        .restart_i(ir_restart), .tick_o(ir_tick)
    );

    frac_tick_div #(.PW(UA_PW), .FRAC_BITS(FRAC_BITS)) u_ua_div (
        .clk(clk), .rst_n(rst_n),
        .period_i(ua_period), .frac_i(ua_frac),
        .restart_i(ua_restart), .tick_o(uart_tick)
    );
endmodule

// File: rtl/baud_tick_gen_chk.sv
// Property checker for baud_tick_gen, attached by bind below.
// Watches only the top-level ports plus its own gap counter.
module baud_tick_gen_chk
    import baud_pkg::*;
#(
    parameter int IR_BITS = IR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              ir_tick,
    input logic              uart_tick,
    input logic              cfg_err
);
    localparam int GAP_W   = IR_BITS + 2;
    localparam int GAP_MAX = 2 ** IR_BITS;

    logic [GAP_W-1:0] ir_gap_q;

    // Cycles since the last infrared tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       ir_gap_q <= '0;
        else if (ir_tick) ir_gap_q <= '0;
        else              ir_gap_q <= ir_gap_q + GAP_W'(1);
    end

    a_r8_ir_single: assert property (@(posedge clk) disable iff (!rst_n)
        ir_tick |=> !ir_tick);
    a_r8_uart_single: assert property (@(posedge clk) disable iff (!rst_n)
        uart_tick |=> !uart_tick);
    a_r8_ir_max_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ir_gap_q <= GAP_W'(GAP_MAX));
    a_r7_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_IR_INT && wr_data[IR_BITS-1:0] == '0) |=> cfg_err);
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.IR_BITS(IR_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ir_tick(ir_tick), .uart_tick(uart_tick),
    .cfg_err(cfg_err)
);

// File: tb/baud_tick_gen_bench.sv
// Self-checking bench: a vector table of channel settings walked by one
// loop, then directed reset and illegal-setting tests.
module baud_tick_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       ir_tick, uart_tick, cfg_err;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    baud_tick_gen u_baud_tick_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ir_tick(ir_tick), .uart_tick(uart_tick),
        .cfg_err(cfg_err)
    );

    always #10 clk = ~clk;

    // Vector: {uart channel, integer byte, fraction byte}
    localparam int NVEC = 9;
    localparam bit [16:0] VEC [NVEC] = '{
        {1'b0, 8'h01, 8'h00},
        {1'b0, 8'h02, 8'h50},
        {1'b0, 8'h0F, 8'hF0},
        {1'b0, 8'h04, 8'h8C},
        {1'b0, 8'h29, 8'h10},
        {1'b1, 8'h00, 8'h00},
        {1'b1, 8'h00, 8'h93},
        {1'b1, 8'h02, 8'hF0},
        {1'b1, 8'h01, 8'h30}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic bit tick_of(input bit sel);
        return sel ? uart_tick : ir_tick;
    endfunction

    task automatic wait_next(input bit sel, output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!tick_of(sel));
    endtask

    task automatic run_vec(input bit sel, input logic [7:0] ib, input logic [7:0] fb);
        int p, f, d, e, sum;
        f = int'(fb[7:4]);
        if (sel) begin
            p = (int'(ib) + 1) * 16;
            wr(2'd2, ib); wr(2'd3, fb);
        end else begin
            p = int'(ib[3:0]) + 1;
            wr(2'd0, ib); wr(2'd1, fb);
        end
        if (!tick_of(sel)) wait_next(sel, d);
        wait_next(sel, d);
        chk(d == p, "R6 first period after restart", d, p);
        sum = 0;
        for (int k = 1; k <= 16; k++) begin
            wait_next(sel, d);
            e = p + (k * f) / 16 - ((k - 1) * f) / 16;
            chk(d == e, "R5 period pattern", d, e);
            sum += d;
        end
        chk(sum == 16 * p + f, sel ? "R3 R4 uart average" : "R2 R4 ir average",
            sum, 16 * p + f);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int first_ir, first_ua, d;
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            chk(ir_tick == 1'b0 && uart_tick == 1'b0, "R1 ticks low in reset",
                int'({ir_tick, uart_tick}), 0);
        end
        chk(cfg_err == 1'b0, "R1 cfg_err clear", int'(cfg_err), 0);
        rst_n = 1'b1;
        first_ir = 0; first_ua = 0;
        for (int i = 1; i <= 20; i++) begin
            @(negedge clk);
            if (ir_tick && first_ir == 0) first_ir = i;
            if (uart_tick && first_ua == 0) first_ua = i;
        end
        chk(first_ir == 1, "R1 first ir tick", first_ir, 1);
        chk(first_ua == 15, "R1 first uart tick", first_ua, 15);

        // R2..R6: vector table
        for (int v = 0; v < NVEC; v++)
            run_vec(VEC[v][16], VEC[v][15:8], VEC[v][7:0]);

        // R7: illegal zero setting is rejected and flagged
        run_vec(1'b0, 8'h03, 8'h00);
        chk(cfg_err == 1'b0, "R7 no error before", int'(cfg_err), 0);
        wr(2'd0, 8'h30);
        chk(cfg_err == 1'b1, "R7 error set", int'(cfg_err), 1);
        wait_next(1'b0, d);
        for (int k = 0; k < 6; k++) begin
            wait_next(1'b0, d);
            chk(d == 4, "R7 ir period kept", d, 4);
        end
        wr(2'd0, 8'h05);
        chk(cfg_err == 1'b1, "R7 error sticky", int'(cfg_err), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule